// File: doc/BRIEF.md
# Push-All / Pop-All Register Sequencer

This block carries out the save-all and restore-all operations of a processor core's general register file. On a start pulse it issues eight stack accesses in a fixed order through a request/acknowledge memory port. A save reads each register through the file's read port and writes it below the stack pointer. A restore reads eight stack slots upward from the stack pointer and loads them into the register file through its write port. The new stack pointer is handed back in a single write when the operation ends.

Two mode inputs select the operand size, 16-bit or 32-bit, and real or protected addressing. Before any access the block runs its fault checks. In real mode it examines small odd stack pointer values on a save. In protected mode it tests the touched stack area against a supplied segment limit. A detected fault ends the operation with no memory, register or stack pointer activity.

Top module: `stack_bulk_seq`

## Requirements
- R1: A save writes register file indices 0 to 7 in ascending order. Access k goes to address sp - (k+1)*n, where n is 2 in 16-bit mode and 4 in 32-bit mode, so index 7 ends at the lowest address. The index encoding is AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7.
- R2: In a save, the value written for slot 4 is the stack pointer sampled at the start pulse, not the register file contents and not any decremented value.
- R3: mem_size is 0 for a 2-byte access and 1 for a 4-byte access. In 16-bit mode, save write data carries the low 16 bits of the value with the upper bits zero.
- R4: A restore reads access k from address sp + k*n. It loads the data into register index 7-k on the acknowledge cycle, and only on a read acknowledge. In 16-bit mode the loaded value is the low 16 bits zero-extended, and rf_wlo is 1 to mark that only the low half is to be updated.
- R5: In a restore, the fourth slot (register index 4) is read from memory but never written into the register file, so exactly seven register writes occur.
- R6: In the done cycle of a completed operation, sp_we is 1. sp_wdata is the starting pointer minus 8*n after a save, or plus 8*n after a restore, using full-width arithmetic.
- R7: In real mode, a save whose starting pointer is 1, 3 or 5 raises shutdown. A starting pointer of 7, 9, 11, 13 or 15 raises fault_gp instead. Restores and protected mode never raise either flag.
- R8: In protected mode, fault_ss is raised in two cases. For a save, it is raised when sp < 8*n or sp-1 > seg_limit. For a restore, it is raised when sp + 8*n - 1 > seg_limit, with the sum evaluated one bit wider than the pointer.
- R9: When a fault is detected, done and exactly one fault flag are high in the cycle after the start pulse. No memory request, register write or stack pointer write occurs.
- R10: Each access holds mem_req, address, direction and data until mem_ack. done is a one-cycle pulse in the cycle after the eighth acknowledge.
- R11: A start pulse that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| restore | input | 1 | 0 = save all, 1 = restore all |
| wide | input | 1 | 0 = 16-bit operands, 1 = 32-bit operands |
| prot | input | 1 | 0 = real mode checks, 1 = protected limit check |
| sp_cur | input | W | Current stack pointer |
| seg_limit | input | W | Highest valid stack segment offset |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | W | New stack pointer |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | W | Register file read data |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | W | Register file write data |
| rf_wlo | output | 1 | Write only the low half of the register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 0 = 2 bytes, 1 = 4 bytes |
| mem_addr | output | W | Byte address of the access |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | W | Read data, valid with mem_ack |
| done | output | 1 | Operation finished (one cycle) |
| shutdown | output | 1 | Real-mode shutdown condition, with done |
| fault_gp | output | 1 | Real-mode exception 13 condition, with done |
| fault_ss | output | 1 | Protected stack limit fault, with done |

## Verification
The assertions watch the per-cycle handshake rules on every cycle:
- requests held stable until acknowledge, and single-cycle done pulses;
- the skipped stack pointer slot on restore, and register writes only on read acknowledges;
- at most one fault flag, which appears only with done, with no stack pointer write and no preceding request.

The access order, the computed addresses, the snapshot value stored in slot 4, the final pointer arithmetic and the exact boundaries of the real-mode and limit checks depend on data values. Only the bench sweeps can show these. The sweeps cover both operand sizes, both modes, several acknowledge latencies, every starting pointer from 0 to 17, and both sides of each limit boundary.

// File: rtl/bulk_pkg.sv
package bulk_pkg;
  localparam int          NSLOT  = 8;
  localparam int          IDX_W  = 3;
  localparam logic [2:0]  IDX_SP = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_END} bulk_state_e;

  typedef struct packed {
    logic shut;
    logic gp;
    logic ss;
  } bulk_flt_t;
endpackage

// File: rtl/bulk_precheck.sv
module bulk_precheck
  import bulk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] sp,
  input  logic         restore,
  input  logic         wide,
  input  logic         prot,
  input  logic [W-1:0] limit,
  output bulk_flt_t    flt
);
  localparam logic [W:0] SPAN_H = (W+1)'(2 * NSLOT);
  localparam logic [W:0] SPAN_F = (W+1)'(4 * NSLOT);
  localparam logic [W:0] ONE    = (W+1)'(1);

  logic [W:0] sp_x;
  logic [W:0] lim_x;
  logic [W:0] span;
  logic       save_bad;
  logic       rest_bad;

  always_comb begin
    sp_x     = {1'b0, sp};
    lim_x    = {1'b0, limit};
    span     = wide ? SPAN_F : SPAN_H;
    // save touches [sp-span, sp-1]; restore touches [sp, sp+span-1]
    save_bad = (sp_x < span) || ((sp_x - ONE) > lim_x);
    rest_bad = ((sp_x + span - ONE) > lim_x);
    flt.shut = !prot && !restore && sp[0] && (sp_x < (W+1)'(7));
    flt.gp   = !prot && !restore && sp[0] && (sp_x >= (W+1)'(7))
               && (sp_x < (W+1)'(16));
    flt.ss   = prot && (restore ? rest_bad : save_bad);
  end
endmodule

// File: rtl/bulk_slot.sv
module bulk_slot
  import bulk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [IDX_W-1:0] step,
  input  logic             restore,
  input  logic             wide,
  input  logic [W-1:0]     rf_rdata,
  input  logic [W-1:0]     snap,
  input  logic [W-1:0]     mem_rdata,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     wr_data,
  output logic [W-1:0]     ld_data,
  output logic             skip
);
  localparam int HW = W / 2;

  logic [W-1:0] src;

  always_comb begin
    // save walks indices upward, restore walks them downward
    idx     = restore ? ~step : step;
    skip    = (idx == IDX_SP);
    src     = skip ? snap : rf_rdata;
    wr_data = wide ? src : {{(W-HW){1'b0}}, src[HW-1:0]};
    ld_data = wide ? mem_rdata : {{(W-HW){1'b0}}, mem_rdata[HW-1:0]};
  end
endmodule

// File: rtl/stack_bulk_seq.sv
module stack_bulk_seq
  import bulk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             restore,
  input  logic             wide,
  input  logic             prot,
  input  logic [W-1:0]     sp_cur,
  input  logic [W-1:0]     seg_limit,
  output logic             sp_we,
  output logic [W-1:0]     sp_wdata,
  output logic [IDX_W-1:0] rf_raddr,
  input  logic [W-1:0]     rf_rdata,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [W-1:0]     rf_wdata,
  output logic             rf_wlo,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_size,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic             mem_ack,
  input  logic [W-1:0]     mem_rdata,
  output logic             done,
  output logic             shutdown,
  output logic             fault_gp,
  output logic             fault_ss
);
  localparam logic [W-1:0]       SZ_H   = W'(2);
  localparam logic [W-1:0]       SZ_F   = W'(4);
  localparam logic [W-1:0]       SPAN_H = W'(2 * NSLOT);
  localparam logic [W-1:0]       SPAN_F = W'(4 * NSLOT);
  localparam logic [IDX_W-1:0]   LAST   = IDX_W'(NSLOT - 1);

  bulk_state_e      st_q, st_d;
  logic [IDX_W-1:0] step_q, step_d;
  logic [W-1:0]     ptr_q, ptr_d;
  logic [W-1:0]     snap_q, snap_d;
  logic             op_q, op_d;
  logic             wide_q, wide_d;
  bulk_flt_t        flt_q, flt_d, flt_chk;
  logic             en;

  logic [IDX_W-1:0] slot_idx;
  logic [W-1:0]     slot_wr;
  logic [W-1:0]     slot_ld;
  logic             slot_skip;
  logic [W-1:0]     sz_q;

  bulk_precheck #(.W(W)) u_chk (
    .sp      (sp_cur),
    .restore (restore),
    .wide    (wide),
    .prot    (prot),
    .limit   (seg_limit),
    .flt     (flt_chk)
  );

  bulk_slot #(.W(W)) u_slot (
    .step      (step_q),
    .restore   (op_q),
    .wide      (wide_q),
    .rf_rdata  (rf_rdata),
    .snap      (snap_q),
    .mem_rdata (mem_rdata),
    .idx       (slot_idx),
    .wr_data   (slot_wr),
    .ld_data   (slot_ld),
    .skip      (slot_skip)
  );

  assign sz_q = wide_q ? SZ_F : SZ_H;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    ptr_d  = ptr_q;
    snap_d = snap_q;
    op_d   = op_q;
    wide_d = wide_q;
    flt_d  = flt_q;
    en     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          en     = 1'b1;
          snap_d = sp_cur;
          op_d   = restore;
          wide_d = wide;
          step_d = '0;
          flt_d  = flt_chk;
          ptr_d  = restore ? sp_cur : sp_cur - (wide ? SZ_F : SZ_H);
          st_d   = (flt_chk != '0) ? ST_END : ST_XFER;
        end
      end
      ST_XFER: begin
        if (mem_ack) begin
          en     = 1'b1;
          ptr_d  = op_q ? ptr_q + sz_q : ptr_q - sz_q;
          step_d = step_q + 1'b1;
          if (step_q == LAST) st_d = ST_END;
        end
      end
      default: begin
        en    = 1'b1;
        st_d  = ST_IDLE;
        flt_d = '0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      ptr_q  <= '0;
      snap_q <= '0;
      op_q   <= 1'b0;
      wide_q <= 1'b0;
      flt_q  <= '0;
    end else if (en) begin
      st_q   <= st_d;
      step_q <= step_d;
      ptr_q  <= ptr_d;
      snap_q <= snap_d;
      op_q   <= op_d;
      wide_q <= wide_d;
      flt_q  <= flt_d;
    end
  end

  // outputs
  always_comb begin
    mem_req   = (st_q == ST_XFER);
    mem_we    = !op_q;
    mem_size  = wide_q;
    mem_addr  = ptr_q;
    mem_wdata = slot_wr;
    rf_raddr  = slot_idx;
    rf_we     = mem_req && mem_ack && op_q && !slot_skip;
    rf_waddr  = slot_idx;
    rf_wdata  = slot_ld;
    rf_wlo    = !wide_q;
    done      = (st_q == ST_END);
    shutdown  = done && flt_q.shut;
    fault_gp  = done && flt_q.gp;
    fault_ss  = done && flt_q.ss;
    sp_we     = done && (flt_q == '0);
    sp_wdata  = op_q ? snap_q + (wide_q ? SPAN_F : SPAN_H)
                     : snap_q - (wide_q ? SPAN_F : SPAN_H);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_SLOT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != IDX_SP)); // R5
  AST_RF_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_ack && !mem_we)); // R4
  AST_FLT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown, fault_gp, fault_ss})); // R7
  AST_FLT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown || fault_gp || fault_ss) |-> (done && !sp_we && !$past(mem_req))); // R9
  AST_SPWE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> done); // R6
endmodule

// File: tb/tb_stack_bulk_seq.sv
module tb_stack_bulk_seq;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, restore = 1'b0, wide = 1'b0, prot = 1'b0;
  logic [W-1:0] sp_cur = '0, seg_limit = '0;
  logic         sp_we, rf_we, rf_wlo, mem_req, mem_we, mem_size;
  logic         done, shutdown, fault_gp, fault_ss;
  logic [W-1:0] sp_wdata, rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
  logic [2:0]   rf_raddr, rf_waddr;
  logic         mem_ack = 1'b0;

  logic [W-1:0] rf_init [8];
  int           lat = 0;
  int           n_acc = 0, base_acc = 0, n_wr = 0, base_wr = 0;
  int           n_done = 0, base_done = 0;
  int           vecs = 0, errs = 0, cycles = 0;
  logic [W-1:0] a_addr [8], a_data [8], w_data [8];
  logic         a_we [8], a_sz [8], w_lo [8];
  logic [2:0]   w_idx [8];
  logic         d_spwe;
  logic [W-1:0] d_spd;
  logic [2:0]   d_flt;

  always #10 clk = ~clk;

  function automatic logic [W-1:0] rd_pat(input logic [W-1:0] a);
    return {8'hC3, a[7:0], ~a[7:0], 8'h3C};
  endfunction

  function automatic logic [W-1:0] msk(input logic wd, input logic [W-1:0] v);
    return wd ? v : {16'h0, v[15:0]};
  endfunction

  assign rf_rdata  = rf_init[rf_raddr];
  assign mem_rdata = rd_pat(mem_addr);

  stack_bulk_seq #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .restore(restore), .wide(wide),
    .prot(prot), .sp_cur(sp_cur), .seg_limit(seg_limit), .sp_we(sp_we),
    .sp_wdata(sp_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_wlo(rf_wlo),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .shutdown(shutdown),
    .fault_gp(fault_gp), .fault_ss(fault_ss)
  );

  // memory responder: acknowledge after lat idle cycles, log each access
  int wcnt = 0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (n_acc - base_acc < 8) begin
          a_addr[n_acc-base_acc] = mem_addr;
          a_data[n_acc-base_acc] = mem_wdata;
          a_we[n_acc-base_acc]   = mem_we;
          a_sz[n_acc-base_acc]   = mem_size;
        end
        n_acc++;
      end else begin
        wcnt++;
      end
    end
  end

  // register, stack pointer and done logger
  always @(posedge clk) begin
    cycles++;
    if (rf_we) begin
      if (n_wr - base_wr < 8) begin
        w_idx[n_wr-base_wr]  = rf_waddr;
        w_data[n_wr-base_wr] = rf_wdata;
        w_lo[n_wr-base_wr]   = rf_wlo;
      end
      n_wr++;
    end
    if (done) begin
      n_done++;
      d_spwe = sp_we;
      d_spd  = sp_wdata;
      d_flt  = {shutdown, fault_gp, fault_ss};
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expf: 0 none, 3'b100 shutdown, 3'b010 exception 13, 3'b001 stack fault
  task automatic run(input bit op, input bit wd, input bit pm,
                     input logic [W-1:0] sp, input logic [W-1:0] lim,
                     input int l, input logic [2:0] expf, input bit poke);
    int          sz = wd ? 4 : 2;
    int          t = 0;
    int          j = 0;
    logic [W-1:0] ea;
    @(negedge clk);
    restore = op; wide = wd; prot = pm; sp_cur = sp; seg_limit = lim; lat = l;
    base_acc = n_acc; base_wr = n_wr; base_done = n_done;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; restore = ~op;  // R11: must be ignored
      @(negedge clk);
      start = 1'b0; restore = op;
    end
    while (n_done == base_done && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(n_done - base_done == 1, "R10 done count", W'(n_done - base_done), 1);
    chk(d_flt == expf, expf[2] ? "R7 shutdown" : expf[1] ? "R7 gp13" :
        expf[0] ? "R8 stack fault" : "R8 no fault", W'(d_flt), W'(expf));
    if (expf != 3'b000) begin
      chk(n_acc == base_acc, "R9 no access", W'(n_acc - base_acc), 0);
      chk(n_wr == base_wr, "R9 no reg write", W'(n_wr - base_wr), 0);
      chk(d_spwe == 1'b0, "R9 no sp write", W'(d_spwe), 0);
    end else begin
      chk(n_acc - base_acc == 8, poke ? "R11 access count" : "R10 access count",
          W'(n_acc - base_acc), 8);
      for (int k = 0; k < 8; k++) begin
        ea = op ? sp + W'(k * sz) : sp - W'((k + 1) * sz);
        chk(a_addr[k] == ea, op ? "R4 address" : "R1 address", a_addr[k], ea);
        chk(a_we[k] == !op, "R1 direction", W'(a_we[k]), W'(!op));
        chk(a_sz[k] == wd, "R3 size", W'(a_sz[k]), W'(wd));
        if (!op) begin
          if (k == 4)
            chk(a_data[k] == msk(wd, sp), "R2 sp snapshot", a_data[k], msk(wd, sp));
          else
            chk(a_data[k] == msk(wd, rf_init[k]), "R3 save data", a_data[k],
                msk(wd, rf_init[k]));
        end
      end
      if (op) begin
        chk(n_wr - base_wr == 7, "R5 write count", W'(n_wr - base_wr), 7);
        j = 0;
        for (int k = 0; k < 8; k++) begin
          if (k != 3) begin
            chk(w_idx[j] == 3'(7 - k), "R5 write index", W'(w_idx[j]), W'(7 - k));
            ea = msk(wd, rd_pat(sp + W'(k * sz)));
            chk(w_data[j] == ea, "R4 load data", w_data[j], ea);
            chk(w_lo[j] == !wd, "R4 low half", W'(w_lo[j]), W'(!wd));
            j++;
          end
        end
      end else begin
        chk(n_wr == base_wr, "R4 no write on save", W'(n_wr - base_wr), 0);
      end
      ea = op ? sp + W'(8 * sz) : sp - W'(8 * sz);
      chk(d_spwe == 1'b1, "R6 sp strobe", W'(d_spwe), 1);
      chk(d_spd == ea, "R6 final sp", d_spd, ea);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf_init[i] = 32'h1111_0000 * (i + 1) + 32'h0101 * (i + 3);
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_req == 0 && rf_we == 0 && sp_we == 0, "R10 reset idle",
        W'({done, mem_req, rf_we, sp_we}), 0);
    rst_n = 1'b1;
    // main sweep
    for (int wd = 0; wd < 2; wd++)
      for (int op = 0; op < 2; op++)
        for (int pm = 0; pm < 2; pm++)
          for (int l = 0; l < 3; l++) begin
            run(op[0], wd[0], pm[0], 32'h0000_0080, 32'hFFFF_FFF0, l, 3'b000, 1'b0);
            run(op[0], wd[0], pm[0], 32'h0001_2346, 32'hFFFF_FFF0, l, 3'b000, 1'b0);
          end
    // real-mode pre-check, every small pointer
    for (int wd = 0; wd < 2; wd++)
      for (int s = 0; s < 18; s++)
        run(1'b0, wd[0], 1'b0, W'(s), '0, 0,
            (s == 1 || s == 3 || s == 5) ? 3'b100 :
            (s[0] && s >= 7 && s <= 15) ? 3'b010 : 3'b000, 1'b0);
    run(1'b1, 1'b0, 1'b0, 32'd3, '0, 0, 3'b000, 1'b0);  // R7: restore unchecked
    run(1'b0, 1'b1, 1'b1, 32'd7, 32'hFF, 0, 3'b001, 1'b0);  // R7 not in protected
    // protected limit boundaries
    run(1'b0, 1'b1, 1'b1, 32'd32,  32'hFF, 1, 3'b000, 1'b0);
    run(1'b0, 1'b1, 1'b1, 32'd31,  32'hFF, 1, 3'b001, 1'b0);
    run(1'b0, 1'b0, 1'b1, 32'd16,  32'hFF, 0, 3'b000, 1'b0);
    run(1'b0, 1'b0, 1'b1, 32'd15,  32'hFF, 0, 3'b001, 1'b0);
    run(1'b0, 1'b1, 1'b1, 32'h81,  32'h80, 0, 3'b000, 1'b0);
    run(1'b0, 1'b1, 1'b1, 32'h82,  32'h80, 0, 3'b001, 1'b0);
    run(1'b1, 1'b1, 1'b1, 32'h40,  32'h5F, 2, 3'b000, 1'b0);
    run(1'b1, 1'b1, 1'b1, 32'h40,  32'h5E, 2, 3'b001, 1'b0);
    run(1'b1, 1'b0, 1'b1, 32'h40,  32'h4F, 0, 3'b000, 1'b0);
    run(1'b1, 1'b0, 1'b1, 32'h40,  32'h4E, 0, 3'b001, 1'b0);
    run(1'b1, 1'b1, 1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 0, 3'b001, 1'b0);
    // start while busy
    run(1'b0, 1'b1, 1'b0, 32'h200, '0, 1, 3'b000, 1'b1);
    run(1'b1, 1'b0, 1'b0, 32'h200, '0, 1, 3'b000, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule